// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block sits between the instruction consumer and the memory bus. It keeps a code segment and a fetch offset, and it forms each 20-bit physical fetch address by shifting the segment left four bits and adding the offset. It uses that address to keep a short byte queue of instruction bytes ahead of the consumer. The consumer takes bytes one at a time from the head of the queue. A jump is signalled by a redirect pulse that carries a new segment and offset. The redirect discards everything queued and restarts fetching at the new location.

The external data width is a parameter. With a two-byte bus, a transfer from an even address brings two bytes. A transfer from an odd address brings only its upper byte, so the next fetch is aligned again. With a one-byte bus, every transfer brings one byte. Only one transfer is in flight at a time on a request/acknowledge bus. The request is held with a stable address until the memory acknowledges it. Data operand traffic is represented by a busy input, and while it is high no new fetch may start.

Top module: `seg_prefetch_unit`

## Requirements
- R1: The fetch address equals segment times 16 plus offset, taken modulo 2^20, so FFFFh:0010h addresses 00000h.
- R2: The fetch offset advances modulo 2^16 and never carries into the segment, so bytes after offset FFFFh come from offset 0000h of the same segment.
- R3: With a two-byte bus, an even-address transfer queues two bytes: first the byte at the even address (data bits 7:0), then the byte at the next address (data bits 15:8).
- R4: With a two-byte bus, an odd-address transfer queues only data bits 15:8, and the following transfer uses the next even address.
- R5: With a one-byte bus, each transfer queues exactly one byte, taken from data bits 7:0.
- R6: The queue holds at most QUEUE_DEPTH (6) bytes, and a new transfer starts only when the free space is at least one bus width. With a two-byte bus and an odd start, the queue therefore rests at 5 bytes.
- R7: Once raised, mem_req stays high with mem_addr unchanged until the cycle in which mem_ack is seen.
- R8: While bus_busy is high, no new transfer starts.
- R9: A redirect empties the queue by the next cycle (q_valid low, q_count zero), and fetching resumes at the new segment:offset.
- R10: A transfer that is pending when a redirect arrives still runs to its acknowledge, and its data is not queued.
- R11: A pop removes the oldest byte. A pop on an empty queue has no effect.
- R12: During reset there is no request and the queue is empty. The first fetch after reset uses RESET_SEG:RESET_OFF (default FFFFh:0000h, address FFFF0h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect | input | 1 | Flush the queue and load a new segment and offset |
| redirect_seg | input | 16 | New code segment |
| redirect_off | input | 16 | New instruction offset |
| bus_busy | input | 1 | Data access owns the bus; hold off new fetches |
| mem_req | output | 1 | Fetch request, held until acknowledged |
| mem_addr | output | 20 | Physical fetch address |
| mem_ack | input | 1 | Memory accepted the request and returns data this cycle |
| mem_rdata | input | 8*BUS_BYTES | Fetched data; byte lanes follow the address |
| pop | input | 1 | Consumer takes the head byte |
| q_valid | output | 1 | Queue holds at least one byte |
| q_byte | output | 8 | Oldest queued byte |
| q_count | output | clog2(QUEUE_DEPTH+1) | Bytes currently queued |

## Verification
The bench builds one two-byte instance and one one-byte instance. It streams bytes from several segment:offset targets and predicts each byte from the arithmetic address of its position. A design that dropped the four-bit segment shift or let the 20-bit sum overflow would return wrong bytes at FFFFh:0010h. A design that let the offset carry into the segment would go wrong after FFFFh, and one that took the wrong lane on odd addresses would go wrong at an odd start. Further sequences cover the following:
- an odd start with no pops, where a design that ignored the free-space rule would overfill;
- a redirect during a slow transfer, where a design that kept the stale data would deliver a wrong first byte;
- pops on an empty queue, where a design that did not ignore them would corrupt the count and the byte order.

// File: rtl/seg_pf_pkg.sv
package seg_pf_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int PHYS_W = 20;

  // segment shifted by four plus offset, truncated to the physical width
  function automatic logic [PHYS_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [OFF_W-1:0] off);
    logic [PHYS_W-1:0] base;
    base = {seg, 4'h0};
    return base + PHYS_W'(off);
  endfunction

  // bytes delivered by one transfer at an address with the given low bit
  function automatic logic [1:0] fetch_bytes(input int bus_bytes, input logic odd);
    if (bus_bytes == 2 && !odd) return 2'd2;
    return 2'd1;
  endfunction
endpackage

// File: rtl/seg_pf_queue.sv
module seg_pf_queue #(
  parameter int DEPTH = 6,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [1:0]       push_cnt,
  input  logic [7:0]       push_lo,
  input  logic [7:0]       push_hi,
  input  logic             pop,
  output logic             valid,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] free,
  output logic             pop_take
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       store_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p,
                                               input logic [1:0] k);
    logic [PTR_W:0] s;
    s = {1'b0, p} + (PTR_W+1)'(k);
    if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  assign valid    = (count_q != '0);
  assign head     = store_q[rd_q];
  assign count    = count_q;
  assign free     = CNT_W'(DEPTH) - count_q;
  assign pop_take = pop && valid && !flush;

  always_ff @(posedge clk) begin
    if (push_cnt != 2'd0) store_q[wr_q] <= push_lo;
    if (push_cnt == 2'd2) store_q[ptr_add(wr_q, 2'd1)] <= push_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      wr_q    <= ptr_add(wr_q, push_cnt);
      rd_q    <= ptr_add(rd_q, {1'b0, pop_take});
      count_q <= count_q + CNT_W'(push_cnt) - CNT_W'(pop_take);
    end
  end
endmodule

// File: rtl/seg_pf_fetch.sv
module seg_pf_fetch
  import seg_pf_pkg::*;
#(
  parameter int          BUS_BYTES = 2,
  parameter int          CNT_W     = 3,
  parameter logic [15:0] RESET_SEG = 16'hFFFF,
  parameter logic [15:0] RESET_OFF = 16'h0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   redirect,
  input  logic [SEG_W-1:0]       redirect_seg,
  input  logic [OFF_W-1:0]       redirect_off,
  input  logic                   bus_busy,
  input  logic [CNT_W-1:0]       free_bytes,
  input  logic                   mem_ack,
  input  logic [BUS_BYTES*8-1:0] mem_rdata,
  output logic                   mem_req,
  output logic [PHYS_W-1:0]      mem_addr,
  output logic [1:0]             push_cnt,
  output logic [7:0]             push_lo,
  output logic [7:0]             push_hi,
  output logic                   drop_pending,
  output logic                   issue_now
);
  logic [SEG_W-1:0]  seg_q;
  logic [OFF_W-1:0]  off_q;
  logic              req_q, drop_q;
  logic [PHYS_W-1:0] addr_q;
  logic              accept;
  logic [1:0]        off_step;

  assign accept    = req_q && mem_ack;
  assign issue_now = !req_q && !redirect && !bus_busy &&
                     (free_bytes >= CNT_W'(BUS_BYTES));
  assign off_step  = fetch_bytes(BUS_BYTES, off_q[0]);
  assign push_cnt  = (accept && !drop_q && !redirect) ?
                     fetch_bytes(BUS_BYTES, addr_q[0]) : 2'd0;
  assign mem_req      = req_q;
  assign mem_addr     = addr_q;
  assign drop_pending = drop_q;

  generate
    if (BUS_BYTES == 2) begin : g_wide
      assign push_lo = addr_q[0] ? mem_rdata[15:8] : mem_rdata[7:0];
      assign push_hi = mem_rdata[15:8];
    end else begin : g_narrow
      assign push_lo = mem_rdata[7:0];
      assign push_hi = 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q  <= RESET_SEG;
      off_q  <= RESET_OFF;
      req_q  <= 1'b0;
      drop_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (accept) begin
        req_q  <= 1'b0;
        drop_q <= 1'b0;
      end
      if (redirect) begin
        seg_q <= redirect_seg;
        off_q <= redirect_off;
        if (req_q && !mem_ack) drop_q <= 1'b1;
      end else if (issue_now) begin
        req_q  <= 1'b1;
        addr_q <= phys_addr(seg_q, off_q);
        off_q  <= off_q + OFF_W'(off_step);
      end
    end
  end
endmodule

// File: rtl/seg_prefetch_unit.sv
module seg_prefetch_unit
  import seg_pf_pkg::*;
#(
  parameter int          BUS_BYTES   = 2,
  parameter int          QUEUE_DEPTH = 6,
  parameter logic [15:0] RESET_SEG   = 16'hFFFF,
  parameter logic [15:0] RESET_OFF   = 16'h0000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 redirect,
  input  logic [15:0]                          redirect_seg,
  input  logic [15:0]                          redirect_off,
  input  logic                                 bus_busy,
  output logic                                 mem_req,
  output logic [19:0]                          mem_addr,
  input  logic                                 mem_ack,
  input  logic [BUS_BYTES*8-1:0]               mem_rdata,
  input  logic                                 pop,
  output logic                                 q_valid,
  output logic [7:0]                           q_byte,
  output logic [$clog2(QUEUE_DEPTH+1)-1:0]     q_count
);
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

  // named internal events, observed by the bound checker
  logic [1:0]       push_cnt;
  logic [7:0]       push_lo, push_hi;
  logic [CNT_W-1:0] free_bytes;
  logic             pop_take;
  logic             fetch_drop;
  logic             fetch_issue;

  seg_pf_fetch #(
    .BUS_BYTES(BUS_BYTES),
    .CNT_W    (CNT_W),
    .RESET_SEG(RESET_SEG),
    .RESET_OFF(RESET_OFF)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .redirect    (redirect),
    .redirect_seg(redirect_seg),
    .redirect_off(redirect_off),
    .bus_busy    (bus_busy),
    .free_bytes  (free_bytes),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .push_cnt    (push_cnt),
    .push_lo     (push_lo),
    .push_hi     (push_hi),
    .drop_pending(fetch_drop),
    .issue_now   (fetch_issue)
  );

  seg_pf_queue #(
    .DEPTH(QUEUE_DEPTH),
    .CNT_W(CNT_W)
  ) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (redirect),
    .push_cnt(push_cnt),
    .push_lo (push_lo),
    .push_hi (push_hi),
    .pop     (pop),
    .valid   (q_valid),
    .head    (q_byte),
    .count   (q_count),
    .free    (free_bytes),
    .pop_take(pop_take)
  );
endmodule

// File: rtl/seg_prefetch_chk.sv
module seg_prefetch_chk #(
  parameter int BUS_BYTES   = 2,
  parameter int QUEUE_DEPTH = 6
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             redirect,
  input logic                             bus_busy,
  input logic                             mem_req,
  input logic                             mem_ack,
  input logic [19:0]                      mem_addr,
  input logic                             q_valid,
  input logic [$clog2(QUEUE_DEPTH+1)-1:0] q_count,
  input logic [1:0]                       push_cnt,
  input logic                             pop_take,
  input logic                             fetch_drop,
  input logic                             fetch_issue
);
  // R6
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count) <= QUEUE_DEPTH);

  // R6
  no_overfill_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && int'(q_count) > QUEUE_DEPTH - BUS_BYTES) |=> !mem_req);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R8
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && bus_busy) |=> !mem_req);

  // R8
  busy_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !fetch_issue);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (q_count == '0 && !q_valid));

  // R10
  flush_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10
  dropped_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_drop || redirect) |-> push_cnt == 2'd0);

  // R3
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !fetch_drop && !redirect) |->
      push_cnt == ((BUS_BYTES == 2 && !mem_addr[0]) ? 2'd2 : 2'd1));

  // R11
  count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> int'(q_count) ==
      int'($past(q_count)) + int'($past(push_cnt)) - int'($past(pop_take)));

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!mem_req && !q_valid));
endmodule

bind seg_prefetch_unit seg_prefetch_chk #(
  .BUS_BYTES  (BUS_BYTES),
  .QUEUE_DEPTH(QUEUE_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .redirect   (redirect),
  .bus_busy   (bus_busy),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .q_valid    (q_valid),
  .q_count    (q_count),
  .push_cnt   (push_cnt),
  .pop_take   (pop_take),
  .fetch_drop (fetch_drop),
  .fetch_issue(fetch_issue)
);

// File: tb/seg_prefetch_unit_test.sv
`timescale 1ns/1ps
module seg_prefetch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redirect = 1'b0;
  logic [15:0] rseg = 16'h0, roff = 16'h0;
  logic        busy = 1'b0;

  logic        req16, ack16 = 1'b0, qv16, pop16 = 1'b0;
  logic [19:0] addr16;
  logic [15:0] rdata16 = 16'h0;
  logic [7:0]  qb16;
  logic [2:0]  qc16;

  logic        req8, ack8 = 1'b0, qv8, pop8 = 1'b0;
  logic [19:0] addr8;
  logic [7:0]  rdata8 = 8'h0;
  logic [7:0]  qb8;
  logic [2:0]  qc8;

  int checks = 0, fails = 0;
  int lat = 1;
  int w16 = 0, w8 = 0, held_err = 0, acks16 = 0, acks8 = 0;
  logic [19:0] held16, held8;

  always #2.5 clk = ~clk;

  seg_prefetch_unit uut (
    .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_seg(rseg),
    .redirect_off(roff), .bus_busy(busy), .mem_req(req16), .mem_addr(addr16),
    .mem_ack(ack16), .mem_rdata(rdata16), .pop(pop16), .q_valid(qv16),
    .q_byte(qb16), .q_count(qc16));

  seg_prefetch_unit #(.BUS_BYTES(1)) uut8 (
    .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_seg(rseg),
    .redirect_off(roff), .bus_busy(busy), .mem_req(req8), .mem_addr(addr8),
    .mem_ack(ack8), .mem_rdata(rdata8), .pop(pop8), .q_valid(qv8),
    .q_byte(qb8), .q_count(qc8));

  function automatic logic [7:0] byte_at(input logic [19:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ {a[19:16], a[19:16]};
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    int unsigned v;
    v = int'(s) * 16 + int'(o);
    return 20'(v % 1048576);
  endfunction

  // memory responders, acting on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin ack16 = 1'b0; w16 = 0; end
    else if (req16 && !ack16) begin
      if (w16 != 0 && addr16 != held16) held_err++;
      held16 = addr16;
      if (w16 >= lat) begin
        ack16 = 1'b1; w16 = 0; acks16++;
        rdata16 = {byte_at(addr16 | 20'h1), byte_at(addr16 & ~20'h1)};
      end else w16++;
    end else ack16 = 1'b0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin ack8 = 1'b0; w8 = 0; end
    else if (req8 && !ack8) begin
      if (w8 != 0 && addr8 != held8) held_err++;
      held8 = addr8;
      if (w8 >= lat) begin
        ack8 = 1'b1; w8 = 0; acks8++;
        rdata8 = byte_at(addr8);
      end else w8++;
    end else ack8 = 1'b0;
  end

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_first(input logic [19:0] exp, input string tag);
    bit s16 = 0, s8 = 0;
    for (int c = 0; c < 100 && !(s16 && s8); c++) begin
      @(negedge clk);
      if (req16 && !s16) begin s16 = 1; chk({tag, " addr16"}, addr16, exp); end
      if (req8 && !s8) begin s8 = 1; chk({tag, " addr8"}, addr8, exp); end
    end
    chk({tag, " first request seen"}, {30'd0, s16, s8}, 3);
  endtask

  task automatic quiesce();
    busy = 1'b1;
    for (int c = 0; c < 100 && (req16 || req8); c++) @(negedge clk);
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] o);
    rseg = s; roff = o; redirect = 1'b1;
    @(negedge clk);
    redirect = 1'b0;
  endtask

  task automatic quiet_redirect(input logic [15:0] s, input logic [15:0] o, input string tag);
    quiesce();
    pulse(s, o);
    busy = 1'b0;
    wait_first(phys(s, o), tag);
  endtask

  task automatic stream(input logic [15:0] s, input logic [15:0] o, input int n, input string tag);
    int g16 = 0, g8 = 0;
    for (int c = 0; c < 3000 && (g16 < n || g8 < n); c++) begin
      pop16 = 1'b0; pop8 = 1'b0;
      if (qv16 && g16 < n) begin
        chk({tag, " byte16"}, qb16, byte_at(phys(s, o + 16'(g16))));
        pop16 = 1'b1; g16++;
      end
      if (qv8 && g8 < n) begin
        chk({tag, " byte8"}, qb8, byte_at(phys(s, o + 16'(g8))));
        pop8 = 1'b1; g8++;
      end
      @(negedge clk);
    end
    pop16 = 1'b0; pop8 = 1'b0;
    chk({tag, " stream complete"}, g16 + g8, 2 * n);
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int a16, a8;
    logic [19:0] a_old;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 req16 in reset", req16, 0);
    chk("R12 req8 in reset", req8, 0);
    chk("R12 valid16 in reset", qv16, 0);
    chk("R12 count8 in reset", qc8, 0);
    rst_n = 1'b1;
    wait_first(20'hFFFF0, "R12");
    stream(16'hFFFF, 16'h0000, 8, "R12");

    // R1 plain address, R3 even-aligned two-byte transfers
    lat = 1;
    quiet_redirect(16'h1000, 16'h0100, "R1");
    stream(16'h1000, 16'h0100, 12, "R3");

    // R1 wrap of the 20-bit sum
    lat = 0;
    quiet_redirect(16'hFFFF, 16'h0010, "R1");
    stream(16'hFFFF, 16'h0010, 10, "R1");

    // R4 odd start
    lat = 2;
    quiet_redirect(16'h2345, 16'h0007, "R4");
    stream(16'h2345, 16'h0007, 9, "R4");

    // R2 offset wraps inside the segment
    lat = 1;
    quiet_redirect(16'h0ABC, 16'hFFFB, "R2");
    stream(16'h0ABC, 16'hFFFB, 12, "R2");

    // R6 fill limit with odd start, R5 one byte per narrow transfer
    lat = 0;
    quiesce();
    a16 = acks16; a8 = acks8;
    pulse(16'h3000, 16'h0101);
    busy = 1'b0;
    repeat (40) @(negedge clk);
    chk("R6 count16 rests at 5", qc16, 5);
    chk("R6 req16 idle when full", req16, 0);
    chk("R6 count8 full", qc8, 6);
    chk("R6 req8 idle when full", req8, 0);
    chk("R5 narrow transfers for 6 bytes", acks8 - a8, 6);
    chk("R3 wide transfers for 5 bytes", acks16 - a16, 3);
    stream(16'h3000, 16'h0101, 5, "R6");

    // R8 busy holds off fetching
    quiesce();
    pulse(16'h4000, 16'h0020);
    repeat (20) @(negedge clk);
    chk("R8 req16 stalled", req16, 0);
    chk("R8 req8 stalled", req8, 0);
    chk("R8 count16 empty", qc16, 0);
    busy = 1'b0;
    stream(16'h4000, 16'h0020, 6, "R8");

    // R9 / R10 redirect over a pending transfer
    lat = 4;
    pulse(16'h5000, 16'h0000);
    for (int c = 0; c < 50 && !req16; c++) @(negedge clk);
    a_old = addr16;
    pulse(16'h6000, 16'h0033);
    chk("R9 count16 flushed", qc16, 0);
    chk("R9 valid16 low", qv16, 0);
    chk("R9 count8 flushed", qc8, 0);
    chk("R10 pending req held", req16, 1);
    chk("R10 pending addr held", addr16, a_old);
    stream(16'h6000, 16'h0033, 10, "R10");

    // R11 pops on empty queue are ignored
    lat = 1;
    quiesce();
    pulse(16'h7000, 16'h0000);
    pop16 = 1'b1; pop8 = 1'b1;
    repeat (3) @(negedge clk);
    pop16 = 1'b0; pop8 = 1'b0;
    chk("R11 count16 after empty pops", qc16, 0);
    chk("R11 count8 after empty pops", qc8, 0);
    busy = 1'b0;
    stream(16'h7000, 16'h0000, 8, "R11");

    // R7 request address never moved while waiting
    chk("R7 address held while waiting", held_err, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule